// File: doc/BRIEF.md
# NAND Page ECC Generator with Readout Sequencing

This block watches the byte stream on a NAND flash data path and builds a 3-byte Hamming-style check code for each 256-byte chunk it sees. It keeps the codes for two chunks, which is enough for a 512-byte page. Software compares them with the codes stored in the spare area and does any correction itself.

A 2-bit mode input controls the block. To start a calculation the host selects clear, then off, then accumulate, and then moves the page. To fetch the result it selects off, then readout, and reads the shared data register three times per chunk. It selects off again when it is done.

The byte input is a valid/ready stream. The block never applies back-pressure: `byte_ready` is high in every cycle, and a byte transfers in any cycle where `byte_valid` is high. Only transfers made while the mode is accumulate change the codes. All other transfers are seen and then discarded. The read strobe and the mode are plain control pins.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, `byte_ready` is 1 and `ecc_byte` is 0x00 in off mode. A readout taken straight after reset returns 0xFF for all six bytes.
- R2: Mode encoding is 00 off, 01 accumulate, 10 readout and 11 clear. `ecc_byte` is 0x00 in every mode except readout.
- R3: `byte_ready` is always 1. A byte with `byte_valid` high in accumulate mode is folded into the code of the current chunk.
- R4: For byte index i (0..255) within a chunk, let p be the XOR of the byte's eight bits. Line parity H[k] is the XOR of p over the bytes with index bit k = 1, and L[k] is the same over the bytes with index bit k = 0. Code byte 0 holds, for k = 0..3, L[k] at bit 2k and H[k] at bit 2k+1. Code byte 1 holds the same for k = 4..7, at bits 2(k-4) and 2(k-4)+1.
- R5: Let X be the XOR of all bytes in the chunk. Code byte 2 holds, at bits 2 through 7 in turn, the parity of X masked with 0x55, 0xAA, 0x33, 0xCC, 0x0F and 0xF0. Bits 1:0 of code byte 2 are 1.
- R6: Every parity bit is output inverted. A chunk of 256 bytes of 0xFF therefore yields 0xFF 0xFF 0xFF.
- R7: Accepted bytes 0..255 go to chunk 0 and bytes 256..511 go to chunk 1. Bytes accepted after 512 have no effect until the next clear.
- R8: In readout mode, the data register gives code byte 1, then byte 0, then byte 2 of chunk 0, followed by the same order for chunk 1. After that the sequence wraps back to chunk 0.
- R9: Readout advances by one byte only on a cycle with `rd_strobe` high. Leaving readout mode returns the readout sequence to its first byte.
- R10: Clear mode resets all parity accumulators, the byte count and the readout position.
- R11: Off mode freezes the accumulators. Bytes transferred in off mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 off, 01 accumulate, 10 readout, 11 clear |
| byte_valid | input | 1 | Data byte present on the NAND path |
| byte_ready | output | 1 | Always 1; the block never stalls the stream |
| byte_data | input | 8 | Data byte |
| rd_strobe | input | 1 | Host read of the data register; one pulse per cycle read |
| ecc_byte | output | 8 | Code byte presented to the data register in readout mode |

## Verification
The assertions assume the following about the inputs:
- `mode` changes only between clock edges.
- `rd_strobe` counts as a read only while the mode is readout.
- The host moves through off between the clear, accumulate and readout phases.

The stimulus drives every input half a cycle away from the active edge. It always enters readout and accumulate through off. It only pulses `rd_strobe` in readout, except in the deliberate checks where bytes are offered in off mode, or beyond the 512-byte capacity, to show that they are ignored.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  localparam int CHUNK_BYTES = 256;
  localparam int IDX_W       = $clog2(CHUNK_BYTES);
  localparam int LINE_W      = 2 * IDX_W;
  localparam int COL_W       = 6;
  localparam int CODE_W      = LINE_W + 8;
  localparam int CODE_BYTES  = CODE_W / 8;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_ACC   = 2'b01,
    MODE_READ  = 2'b10,
    MODE_CLEAR = 2'b11
  } ecc_mode_e;

  // Column parities of a folded byte: even/odd bits, bit pairs, nibbles.
  function automatic logic [COL_W-1:0] col_parity(input logic [7:0] x);
    logic [COL_W-1:0] c;
    c[0] = ^(x & 8'h55);
    c[1] = ^(x & 8'hAA);
    c[2] = ^(x & 8'h33);
    c[3] = ^(x & 8'hCC);
    c[4] = ^(x & 8'h0F);
    c[5] = ^(x & 8'hF0);
    return c;
  endfunction

endpackage

// File: rtl/ecc_chunk_acc.sv
module ecc_chunk_acc
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        data,
  output logic [CODE_W-1:0] code
);

  logic [IDX_W-1:0] lp_hi;
  logic [IDX_W-1:0] lp_lo;
  logic [7:0]       col_x;
  logic             byte_par;
  logic [LINE_W-1:0] lines;
  logic [COL_W-1:0]  cols;

  assign byte_par = ^data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_hi <= '0;
      lp_lo <= '0;
      col_x <= '0;
    end else if (clr) begin
      lp_hi <= '0;
      lp_lo <= '0;
      col_x <= '0;
    end else if (en) begin
      lp_hi <= lp_hi ^ (idx & {IDX_W{byte_par}});
      lp_lo <= lp_lo ^ (~idx & {IDX_W{byte_par}});
      col_x <= col_x ^ data;
    end
  end

  // Interleave low/high line parities, stored inverted.
  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lines[2*k]   = ~lp_lo[k];
    assign lines[2*k+1] = ~lp_hi[k];
  end

  assign cols = ~col_parity(col_x);
  assign code = {cols, 2'b11, lines};

  // R10: clear empties this chunk's accumulators
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lp_hi == '0 && lp_lo == '0 && col_x == '0));

  // R11: without enable the code is frozen
  assert_frozen_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(code));

endmodule

// File: rtl/ecc_byte_counter.sv
module ecc_byte_counter
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int TOTAL  = NUM_CHUNKS * CHUNK_BYTES,
  localparam int CNT_W  = $clog2(TOTAL + 1),
  localparam int SEL_W  = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic [SEL_W-1:0] sel,
  output logic             full
);

  logic [CNT_W-1:0] cnt;

  assign full = (cnt == CNT_W'(TOTAL));
  assign idx  = cnt[IDX_W-1:0];
  assign sel  = SEL_W'(cnt >> IDX_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (step && !full)
      cnt <= cnt + 1'b1;
  end

  // R7: the count never runs past the page capacity
  assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TOTAL));

  // R10: clear returns the count to zero
  assert_count_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R7: once full, further steps leave the count alone
  assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);

endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int SEL_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             active,
  input  logic                             strobe,
  input  logic [NUM_CHUNKS-1:0][CODE_W-1:0] codes,
  output logic [7:0]                       out_byte
);

  logic [1:0]       pos;
  logic [SEL_W-1:0] chunk;
  logic [CODE_W-1:0] cur;
  logic             last_pos;
  logic             last_chunk;

  assign last_pos   = (pos == 2'd2);
  assign last_chunk = (chunk == SEL_W'(NUM_CHUNKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      chunk <= '0;
    end else if (!active) begin
      pos   <= '0;
      chunk <= '0;
    end else if (strobe) begin
      if (last_pos) begin
        pos   <= '0;
        chunk <= last_chunk ? '0 : chunk + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign cur = codes[chunk];

  // Swapped order inside a chunk: byte 1, byte 0, byte 2.
  always_comb begin
    out_byte = 8'h00;
    if (active) begin
      unique case (pos)
        2'd0:    out_byte = cur[15:8];
        2'd1:    out_byte = cur[7:0];
        default: out_byte = cur[23:16];
      endcase
    end
  end

  // R9: outside readout the sequence sits at its first byte
  assert_restart_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (pos == 2'd0 && chunk == '0));

  // R9: no strobe, no advance
  assert_hold_without_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !strobe) |=> ($stable(pos) && $stable(chunk)));

  // R8: position stays within the three bytes of a chunk
  assert_pos_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pos != 2'd3);

  // R8: a read of the third byte of the last chunk wraps to the start
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && strobe && last_pos && last_chunk) |=> (pos == 2'd0 && chunk == '0));

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int NUM_CHUNKS = 2,
  localparam int SEL_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       byte_valid,
  output logic       byte_ready,
  input  logic [7:0] byte_data,
  input  logic       rd_strobe,
  output logic [7:0] ecc_byte
);

  ecc_mode_e        mode_e;
  logic             clr;
  logic             accept;
  logic             full;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] sel;
  logic [NUM_CHUNKS-1:0][CODE_W-1:0] codes;

  assign mode_e     = ecc_mode_e'(mode);
  assign clr        = (mode_e == MODE_CLEAR);
  assign byte_ready = 1'b1;
  assign accept     = byte_valid && (mode_e == MODE_ACC) && !full;

  ecc_byte_counter #(.NUM_CHUNKS(NUM_CHUNKS)) u_count (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .step (accept),
    .idx  (idx),
    .sel  (sel),
    .full (full)
  );

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    ecc_chunk_acc u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .en   (accept && (sel == SEL_W'(g))),
      .idx  (idx),
      .data (byte_data),
      .code (codes[g])
    );
  end

  ecc_readout #(.NUM_CHUNKS(NUM_CHUNKS)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (mode_e == MODE_READ),
    .strobe  (rd_strobe),
    .codes   (codes),
    .out_byte(ecc_byte)
  );

  // R11: a byte offered in off mode leaves every code unchanged
  assert_off_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_OFF) |=> $stable(codes));

  // R2: the register reads zero unless in readout
  assert_quiet_outside_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e != MODE_READ) |-> (ecc_byte == 8'h00));

endmodule

// File: tb/tb_nand_ecc_gen.sv
module tb_nand_ecc_gen;

  localparam logic [1:0] M_OFF = 2'b00, M_ACC = 2'b01, M_RD = 2'b10, M_CLR = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = M_OFF;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic [7:0] byte_data = 8'h00;
  logic       rd_strobe = 1'b0;
  logic [7:0] ecc_byte;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [512];
  int acc_cnt = 0;

  always #5 clk = ~clk;

  nand_ecc_gen dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .byte_data(byte_data), .rd_strobe(rd_strobe),
    .ecc_byte(ecc_byte)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Reference code of a chunk from the requirement text.
  function automatic logic [23:0] ref_code(input int base, input int n);
    logic [7:0] hi = '0, lo = '0, x = '0, b0, b1, b2;
    for (int i = 0; i < n; i++) begin
      logic p = ^mem[base + i];
      x ^= mem[base + i];
      for (int k = 0; k < 8; k++)
        if (((i >> k) & 1) == 1) hi[k] ^= p; else lo[k] ^= p;
    end
    for (int k = 0; k < 4; k++) begin
      b0[2*k] = ~lo[k];   b0[2*k+1] = ~hi[k];
      b1[2*k] = ~lo[k+4]; b1[2*k+1] = ~hi[k+4];
    end
    b2[1:0] = 2'b11;
    b2[2] = ~^(x & 8'h55); b2[3] = ~^(x & 8'hAA);
    b2[4] = ~^(x & 8'h33); b2[5] = ~^(x & 8'hCC);
    b2[6] = ~^(x & 8'h0F); b2[7] = ~^(x & 8'hF0);
    return {b2, b1, b0};
  endfunction

  function automatic logic [7:0] expect_read(input int r);
    int c = (r / 3) % 2;
    int base = c * 256;
    int n = acc_cnt - base;
    logic [23:0] code;
    if (n < 0) n = 0;
    if (n > 256) n = 256;
    code = ref_code(base, n);
    case (r % 3)
      0: return code[15:8];
      1: return code[7:0];
      default: return code[23:16];
    endcase
  endfunction

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    if (mode == M_ACC && acc_cnt < 512) begin
      mem[acc_cnt] = b;
      acc_cnt++;
    end
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic start_calc();
    set_mode(M_CLR);
    acc_cnt = 0;
    set_mode(M_OFF);
    set_mode(M_ACC);
  endtask

  task automatic read_all(input int nreads, input string tag);
    set_mode(M_OFF);
    set_mode(M_RD);
    for (int r = 0; r < nreads; r++) begin
      chk(ecc_byte, expect_read(r), tag);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
    end
    set_mode(M_OFF);
  endtask

  function automatic logic [7:0] gen(input int kind, input int i);
    case (kind)
      0: return 8'hFF;
      1: return 8'(i);
      2: return 8'((i * 37 + (i >> 3) * 11) ^ 8'h5A);
      default: return (i == 37) ? 8'h08 : 8'h00;
    endcase
  endfunction

  task automatic t_reset();
    chk({7'd0, byte_ready}, 8'h01, "R1 ready after reset");
    chk(ecc_byte, 8'h00, "R1 ecc_byte off after reset");
    read_all(6, "R1 readout after reset");
  endtask

  task automatic t_page(input int kind, input string tag);
    start_calc();
    for (int i = 0; i < 512; i++) send(gen(kind, i));
    read_all(6, tag);
  endtask

  task automatic t_wrap();
    read_all(9, "R8 wrap to chunk 0");
  endtask

  task automatic t_hold_and_restart();
    logic [7:0] first;
    set_mode(M_RD);
    first = ecc_byte;
    repeat (3) @(negedge clk);
    chk(ecc_byte, first, "R9 hold without strobe");
    chk(ecc_byte, expect_read(0), "R9 first byte");
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    chk(ecc_byte, expect_read(1), "R9 advance on strobe");
    set_mode(M_OFF);
    chk(ecc_byte, 8'h00, "R2 zero in off");
    set_mode(M_RD);
    chk(ecc_byte, expect_read(0), "R9 restart after leaving readout");
    set_mode(M_OFF);
  endtask

  task automatic t_off_freeze();
    start_calc();
    for (int i = 0; i < 100; i++) send(gen(2, i));
    set_mode(M_OFF);
    for (int i = 0; i < 50; i++) send(8'hA5 ^ 8'(i));
    set_mode(M_ACC);
    chk(ecc_byte, 8'h00, "R2 zero in accumulate");
    for (int i = 100; i < 512; i++) send(gen(1, i));
    read_all(6, "R11 off mode ignores bytes");
  endtask

  task automatic t_partial_and_overflow();
    start_calc();
    for (int i = 0; i < 300; i++) send(gen(2, i + 7));
    read_all(6, "R7 partial second chunk");
    set_mode(M_ACC);
    for (int i = 300; i < 512; i++) send(gen(1, i));
    for (int i = 0; i < 10; i++) send(8'h3C + 8'(i));
    read_all(6, "R7 bytes past capacity ignored");
  endtask

  task automatic t_clear();
    set_mode(M_CLR);
    acc_cnt = 0;
    chk(ecc_byte, 8'h00, "R2 zero in clear");
    read_all(6, "R10 clear resets codes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page(0, "R6 erased page");
    t_page(1, "R4 incrementing page");
    t_wrap();
    t_hold_and_restart();
    t_page(2, "R5 scrambled page");
    t_page(3, "R3 single bit page");
    t_off_freeze();
    t_partial_and_overflow();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule